// File: doc/BRIEF.md
# Receive Flush and Transmit Inhibit Controller

This block gives one external control pin two possible meanings, chosen by a mode input. In flush mode, an assertion of the pin during a received frame discards that frame. The receive buffer write pointer is wound back to the pointer saved at the start of the frame, so the partial frame leaves no data in the buffer. The pin acts whatever the address-match result for that frame was. A programmable word threshold limits how late in a frame a flush request may arrive. In inhibit mode, the pin has no effect on reception. It stops new transmit frames from starting, and a frame already on the wire runs to its normal end.

The receive side follows frame start and end strobes and a per-word write strobe. It keeps two pointers: the live write pointer and the saved start-of-frame pointer. The transmit side places a grant between a start request and the transmitter, and it tracks whether a transmit frame is in progress until that frame ends. The pin is taken as synchronous to the block clock.

Top module: `flush_inhibit_ctrl`

## Requirements
- R1: After reset, the write pointer and the saved frame pointer are both zero, and no flush pulse, grant or transmit-busy indication is present.
- R2: Each word write strobe inside a frame advances the write pointer by one, wrapping modulo 2^PTR_W. Strobes in the frame start cycle are not counted.
- R3: During a frame the saved pointer holds its value. At the end of a frame that is not flushed, the saved pointer takes the write pointer value that includes the frame's words.
- R4: With mode_i = 0 (flush) and threshold 0, a pin assertion in any cycle after the start cycle discards the frame. The cycle after frame end, the write pointer equals the saved pointer and flushed_o is high for exactly one cycle.
- R5: With a nonzero threshold T, a pin assertion is accepted only in a cycle where fewer than T words of the frame have been written. An assertion after T words is ignored.
- R6: With threshold 0, a pin assertion in the frame end cycle itself still discards the frame.
- R7: An accepted flush request is cleared at frame end, so the next frame is kept unless the pin asserts again within it.
- R8: A pin assertion outside a frame has no effect on either pointer or on the next frame.
- R9: With mode_i = 1 (inhibit), the pin has no effect on reception, and frames are kept.
- R10: In inhibit mode a pin assertion does not end a transmit frame already granted. While the pin is high no grant is given, and a pending request is granted in the cycle after the pin falls.
- R11: In flush mode the pin does not affect transmit grants.
- R12: A grant is given combinationally to a request when no transmit frame is busy. Busy rises the cycle after a grant and stays high until the transmit end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Pin function: 0 receive flush, 1 transmit inhibit |
| pin_i | input | 1 | External flush/inhibit pin, synchronous |
| rx_thr_i | input | THR_W | Receive word threshold for flush acceptance, 0 = no limit |
| frame_start_i | input | 1 | Receive frame start strobe |
| frame_end_i | input | 1 | Receive frame end strobe |
| word_wr_i | input | 1 | Receive word written to buffer |
| wr_ptr_o | output | PTR_W | Buffer write pointer |
| sof_ptr_o | output | PTR_W | Saved start-of-frame pointer |
| flushed_o | output | 1 | One-cycle pulse after a discarded frame ends |
| tx_req_i | input | 1 | Request to start a transmit frame |
| tx_end_i | input | 1 | Current transmit frame has ended |
| tx_grant_o | output | 1 | Start of transmit frame granted |
| tx_busy_o | output | 1 | Transmit frame in progress |

## Verification
The assertions rely on well-formed input framing. A frame start and a frame end never fall in the same cycle. A new start comes only outside a frame. The transmit end strobe arrives only while a transmit frame is busy. The threshold and mode stay constant for the whole of a frame. The directed tasks keep to these rules: each scenario drives one complete frame with one strobe per cycle, changes the threshold and mode only between frames, and raises the transmit end strobe only after it has seen busy high.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic {
    PIN_FLUSH   = 1'b0,
    PIN_INHIBIT = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/fic_flush_arb.sv
module fic_flush_arb #(
  parameter int THR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_sel_i,
  input  logic             pin_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             word_wr_i,
  output logic             in_frame_o,
  output logic             flush_take_o,
  output logic             flushed_o
);
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  logic             in_frame_q;
  logic [THR_W-1:0] wcnt_q;
  logic             pend_q;
  logic             flushed_q;
  logic             below_thr;
  logic             accept;

  assign below_thr    = (thr_i == '0) || (wcnt_q < thr_i);
  assign accept       = in_frame_q && flush_sel_i && pin_i && below_thr;
  assign flush_take_o = frame_end_i && in_frame_q && (pend_q || accept);
  assign in_frame_o   = in_frame_q;
  assign flushed_o    = flushed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
    end else if (frame_start_i) begin
      in_frame_q <= 1'b1;
    end else if (frame_end_i) begin
      in_frame_q <= 1'b0;
    end
  end

  // words seen in this frame, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
    end else if (frame_start_i) begin
      wcnt_q <= '0;
    end else if (in_frame_q && word_wr_i && (wcnt_q != CNT_MAX)) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (frame_start_i || frame_end_i) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flushed_q <= 1'b0;
    end else begin
      flushed_q <= flush_take_o;
    end
  end

  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> !pend_q); // R7

  AST_LATE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && (thr_i != '0) && (wcnt_q >= thr_i) && !pend_q) |=> !pend_q); // R5

  AST_IDLE_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !frame_start_i) |=> !pend_q); // R8

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushed_q |=> !flushed_q); // R4
endmodule

// File: rtl/fic_rx_ptr.sv
module fic_rx_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_frame_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             word_wr_i,
  input  logic             flush_take_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] sof_ptr_o
);
  logic [PTR_W-1:0] wr_q;
  logic [PTR_W-1:0] sof_q;
  logic [PTR_W-1:0] wr_next;

  assign wr_next   = wr_q + PTR_W'(in_frame_i && word_wr_i);
  assign wr_ptr_o  = wr_q;
  assign sof_ptr_o = sof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
    end else if (flush_take_i) begin
      wr_q <= sof_q;
    end else begin
      wr_q <= wr_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_q <= '0;
    end else if (frame_start_i) begin
      sof_q <= wr_q;
    end else if (frame_end_i && in_frame_i && !flush_take_i) begin
      sof_q <= wr_next;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i && word_wr_i && !frame_end_i) |=> (wr_ptr_o == $past(wr_ptr_o) + PTR_W'(1))); // R2

  AST_FLUSH_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_take_i |=> (wr_ptr_o == $past(sof_ptr_o))); // R4

  AST_SOF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_i && !frame_end_i && !frame_start_i) |=> $stable(sof_ptr_o)); // R3

  AST_KEEP_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && in_frame_i && !flush_take_i) |=> (sof_ptr_o == wr_ptr_o)); // R3
endmodule

// File: rtl/fic_tx_gate.sv
module fic_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_sel_i,
  input  logic pin_i,
  input  logic tx_req_i,
  input  logic tx_end_i,
  output logic tx_grant_o,
  output logic tx_busy_o
);
  logic block_q;
  logic busy_q;
  logic block_now;

  assign block_now  = inhibit_sel_i && pin_i;
  // block_q holds off the grant one cycle past the pin falling
  assign tx_grant_o = tx_req_i && !busy_q && !block_q && !block_now;
  assign tx_busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_q <= 1'b0;
    end else begin
      block_q <= block_now;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (tx_grant_o) begin
      busy_q <= 1'b1;
    end else if (tx_end_i) begin
      busy_q <= 1'b0;
    end
  end

  AST_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |=> tx_busy_o); // R12

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && !tx_end_i) |=> tx_busy_o); // R10
endmodule

// File: rtl/flush_inhibit_ctrl.sv
module flush_inhibit_ctrl
  import fic_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int THR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             pin_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             word_wr_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] sof_ptr_o,
  output logic             flushed_o,
  input  logic             tx_req_i,
  input  logic             tx_end_i,
  output logic             tx_grant_o,
  output logic             tx_busy_o
);
  pin_mode_e mode;
  logic      flush_sel;
  logic      inhibit_sel;
  logic      in_frame;
  logic      flush_take;

  assign mode        = pin_mode_e'(mode_i);
  assign flush_sel   = (mode == PIN_FLUSH);
  assign inhibit_sel = (mode == PIN_INHIBIT);

  fic_flush_arb #(.THR_W(THR_W)) u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_sel_i   (flush_sel),
    .pin_i         (pin_i),
    .thr_i         (rx_thr_i),
    .frame_start_i (frame_start_i),
    .frame_end_i   (frame_end_i),
    .word_wr_i     (word_wr_i),
    .in_frame_o    (in_frame),
    .flush_take_o  (flush_take),
    .flushed_o     (flushed_o)
  );

  fic_rx_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_frame_i    (in_frame),
    .frame_start_i (frame_start_i),
    .frame_end_i   (frame_end_i),
    .word_wr_i     (word_wr_i),
    .flush_take_i  (flush_take),
    .wr_ptr_o      (wr_ptr_o),
    .sof_ptr_o     (sof_ptr_o)
  );

  fic_tx_gate u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .inhibit_sel_i (inhibit_sel),
    .pin_i         (pin_i),
    .tx_req_i      (tx_req_i),
    .tx_end_i      (tx_end_i),
    .tx_grant_o    (tx_grant_o),
    .tx_busy_o     (tx_busy_o)
  );
endmodule

// File: tb/flush_inhibit_ctrl_tb.sv
module flush_inhibit_ctrl_tb;
  localparam int PTR_W = 8;
  localparam int THR_W = 6;
  localparam int PMOD  = 1 << PTR_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode, pin, fstart, fend, wwr, txreq, txend;
  logic [THR_W-1:0] thr;
  logic [PTR_W-1:0] wr_ptr, sof_ptr;
  logic             flushed, grant, busy;

  int checks = 0;
  int errors = 0;
  int exp_wr = 0;
  int exp_sof = 0;

  always #10 clk = ~clk;

  flush_inhibit_ctrl #(.PTR_W(PTR_W), .THR_W(THR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pin_i(pin), .rx_thr_i(thr),
    .frame_start_i(fstart), .frame_end_i(fend), .word_wr_i(wwr),
    .wr_ptr_o(wr_ptr), .sof_ptr_o(sof_ptr), .flushed_o(flushed),
    .tx_req_i(txreq), .tx_end_i(txend), .tx_grant_o(grant), .tx_busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // one receive frame; pin_at = word index with pin high (-1 none)
  task automatic rx_frame(input int n, input int pin_at, input bit pin_end,
                          input int t, input bit inh, input string req);
    bit fl;
    mode = inh; thr = THR_W'(t);
    fstart = 1'b1; cyc(); fstart = 1'b0;
    for (int i = 0; i < n; i++) begin
      wwr = 1'b1; pin = (i == pin_at); cyc();
    end
    wwr = 1'b0; pin = 1'b0;
    chk({req, " mid wr"}, int'(wr_ptr), (exp_wr + n) % PMOD);
    chk({req, " mid sof R3"}, int'(sof_ptr), exp_sof);
    fend = 1'b1; pin = pin_end; cyc(); fend = 1'b0; pin = 1'b0;
    fl = !inh && ((pin_at >= 0 && pin_at < n && (t == 0 || pin_at < t)) ||
                  (pin_end && (t == 0 || n < t)));
    if (!fl) begin
      exp_wr  = (exp_wr + n) % PMOD;
      exp_sof = exp_wr;
    end
    chk({req, " end wr"}, int'(wr_ptr), exp_wr);
    chk({req, " end sof"}, int'(sof_ptr), exp_sof);
    chk({req, " flushed"}, int'(flushed), int'(fl));
    cyc();
    chk({req, " flushed pulse"}, int'(flushed), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 1'b0; pin = 1'b0; fstart = 1'b0; fend = 1'b0;
    wwr = 1'b0; txreq = 1'b0; txend = 1'b0; thr = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 wr", int'(wr_ptr), 0);
    chk("R1 sof", int'(sof_ptr), 0);
    chk("R1 flushed", int'(flushed), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 grant", int'(grant), 0);
  endtask

  task automatic t_idle_pin();
    mode = 1'b0; pin = 1'b1;
    repeat (4) cyc();
    pin = 1'b0;
    chk("R8 idle wr", int'(wr_ptr), exp_wr);
    chk("R8 idle sof", int'(sof_ptr), exp_sof);
    rx_frame(4, -1, 1'b0, 0, 1'b0, "R8");
  endtask

  task automatic t_tx_basic();
    mode = 1'b0; txreq = 1'b1; #1;
    chk("R12 grant idle", int'(grant), 1);
    cyc(); #1;
    chk("R12 busy after grant", int'(busy), 1);
    chk("R12 no grant busy", int'(grant), 0);
    txreq = 1'b0; txend = 1'b1; cyc(); txend = 1'b0;
    chk("R12 busy cleared", int'(busy), 0);
  endtask

  task automatic t_tx_inhibit();
    mode = 1'b1; txreq = 1'b1; #1;
    chk("R10 first grant", int'(grant), 1);
    cyc(); txreq = 1'b0; pin = 1'b1;
    cyc();
    chk("R10 frame continues", int'(busy), 1);
    txend = 1'b1; cyc(); txend = 1'b0;
    chk("R10 frame ended", int'(busy), 0);
    txreq = 1'b1; #1;
    chk("R10 blocked", int'(grant), 0);
    for (int i = 0; i < 3; i++) begin
      cyc(); #1;
      chk("R10 still blocked", int'(grant), 0);
    end
    pin = 1'b0; #1;
    chk("R10 fall cycle", int'(grant), 0);
    cyc(); #1;
    chk("R10 resumed", int'(grant), 1);
    cyc(); txreq = 1'b0;
    chk("R10 busy", int'(busy), 1);
    txend = 1'b1; cyc(); txend = 1'b0;
    mode = 1'b0;
  endtask

  task automatic t_tx_flush_mode();
    mode = 1'b0; pin = 1'b1; txreq = 1'b1; #1;
    chk("R11 grant with pin", int'(grant), 1);
    cyc(); txreq = 1'b0; pin = 1'b0;
    chk("R11 busy", int'(busy), 1);
    chk("R11 wr untouched", int'(wr_ptr), exp_wr);
    txend = 1'b1; cyc(); txend = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    rx_frame(5, -1, 1'b0, 0, 1'b0, "R2 R3 plain");
    rx_frame(6, 2, 1'b0, 0, 1'b0, "R4 flush");
    rx_frame(3, -1, 1'b0, 0, 1'b0, "R7 after flush");
    rx_frame(7, 2, 1'b0, 4, 1'b0, "R5 early");
    rx_frame(7, 3, 1'b0, 4, 1'b0, "R5 last ok");
    rx_frame(7, 4, 1'b0, 4, 1'b0, "R5 late");
    rx_frame(10, -1, 1'b1, 0, 1'b0, "R6 end cycle");
    rx_frame(10, -1, 1'b1, 4, 1'b0, "R5 end late");
    t_idle_pin();
    rx_frame(6, 1, 1'b1, 0, 1'b1, "R9 inhibit");
    rx_frame(300, -1, 1'b0, 0, 1'b0, "R2 wrap");
    t_tx_basic();
    t_tx_inhibit();
    t_tx_flush_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule